// File: doc/BRIEF.md
# Interrupt Source P/Q Trigger Gate

This block holds a bank of interrupt sources. Each source keeps a two-bit P/Q state that decides whether an incoming trigger becomes a notification to a downstream interrupt controller. A trigger or an end-of-interrupt (EOI) on a source steps its P/Q pair. When a step calls for a notification, the source raises a pending request. A round-robin arbiter sends the pending requests out one per cycle through a valid/ready handshake. Each notification carries the source number and a flag that says whether the P/Q gating was done locally.

A global offload input changes how message-type sources are handled. With offload set, a trigger on a message-type source skips local gating. It is always forwarded, with the checked flag cleared, and the source's P/Q state stays as it was. An EOI on such a source is invalid: it is dropped and an error pulse is raised. Level-type sources ignore the offload input and stay gated locally, so the controller can follow their assertion level. A level source that still has its level input high at EOI is retriggered in the same cycle.

Top module: `pq_trigger_gate`

## Requirements
- R1: After reset every source is in P/Q state 00 (P is bit 1, Q is bit 0). No notification is valid and the error flag is low.
- R2: In gated mode, a trigger moves 00 to 10 and raises a notification with checked=1. A trigger in 10 or 11 moves to 11 and raises nothing. State 01 is never reached.
- R3: In gated mode, an EOI moves 11 to 10 and raises a notification with checked=1. An EOI in any other state moves to 00 and raises nothing.
- R4: When a trigger and an EOI reach the same gated source in one cycle, the EOI step is applied first and the trigger step is applied to its result. At most one notification results.
- R5: An EOI on a level-type source (`is_lsi_i` bit = 1) whose `level_i` bit is high acts as an EOI followed by a trigger in the same cycle.
- R6: With `pq_off_i`=1, every trigger on a message-type source (`is_lsi_i` bit = 0) raises a notification with checked=0 and leaves that source's P/Q state unchanged.
- R7: `pq_off_i` has no effect on level-type sources. They follow R2 to R5 and their notifications carry checked=1.
- R8: With `pq_off_i`=1, an EOI on an in-range message-type source leaves its state unchanged and raises no notification. It drives `eoi_err_o` high for exactly the cycle after the EOI edge.
- R9: Triggers and EOIs on a source whose index is not below `src_count_i` have no effect at all.
- R10: While `ntf_valid_o`=1 and `ntf_ready_i`=0, the valid, source and checked outputs hold. A pending request is kept until it is accepted.
- R11: Pending requests are granted round-robin, one per cycle. The search starts at the index after the last granted source (index 0 after reset).
- R12: A notification raised at clock edge N appears on `ntf_valid_o` after edge N+1, provided the output stage is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pq_off_i | input | 1 | Offload mode: message-type sources skip local P/Q gating |
| src_count_i | input | $clog2(NUM_SRC+1) | Number of sources in use; higher indices are ignored |
| is_lsi_i | input | NUM_SRC | Per-source type: 1 = level, 0 = message |
| level_i | input | NUM_SRC | Per-source level state, used at EOI on level sources |
| trig_i | input | NUM_SRC | Per-source trigger event, one cycle per event |
| eoi_i | input | NUM_SRC | Per-source EOI request, one cycle per request |
| ntf_valid_o | output | 1 | Notification valid |
| ntf_ready_i | input | 1 | Downstream accepts the notification |
| ntf_src_o | output | $clog2(NUM_SRC) | Source number of the notification |
| ntf_checked_o | output | 1 | 1 when the P/Q check was done locally |
| eoi_err_o | output | 1 | One-cycle pulse for an invalid EOI under offload |

## Verification
The assertions expect `trig_i`, `eoi_i`, `is_lsi_i`, `level_i`, `pq_off_i` and `src_count_i` to be driven synchronously and held stable around each edge. They also expect the downstream to leave `ntf_ready_i` free to change in any cycle. The stimulus changes every input at the falling edge only. It changes the source type and the offload mode only between phases, and never while a request is pending. Each phase issues one trigger, EOI or combined operation and then waits for the notification to drain. A separate stall sequence holds ready low with several requests pending.

// File: rtl/pq_gate_pkg.sv
package pq_gate_pkg;

  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_Q_ONLY = 2'b01,
    PQ_P_ONLY = 2'b10,
    PQ_BOTH   = 2'b11
  } pq_e;

  typedef struct packed {
    pq_e  pq;
    logic ntf;
  } pq_step_t;

  // trigger: only an idle source notifies, everything else saturates to 11
  function automatic pq_step_t pq_trigger(pq_e cur);
    pq_step_t r;
    if (cur == PQ_RESET) begin
      r.pq  = PQ_P_ONLY;
      r.ntf = 1'b1;
    end else begin
      r.pq  = PQ_BOTH;
      r.ntf = 1'b0;
    end
    return r;
  endfunction

  // eoi: a queued event (Q set with P) is replayed, else drop to idle
  function automatic pq_step_t pq_eoi(pq_e cur);
    pq_step_t r;
    if (cur == PQ_BOTH) begin
      r.pq  = PQ_P_ONLY;
      r.ntf = 1'b1;
    end else begin
      r.pq  = PQ_RESET;
      r.ntf = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/pq_src_cell.sv
module pq_src_cell
  import pq_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pq_off_i,
  input  logic lsi_i,
  input  logic level_i,
  input  logic trig_i,
  input  logic eoi_i,
  input  logic take_i,
  output logic pend_o,
  output logic chk_o,
  output logic err_o
);

  pq_e      pq_q, pq_d;
  logic     pend_q, chk_q;
  logic     bypass, do_eoi, do_trig;
  logic     ntf, ntf_chk;
  pq_step_t s_eoi, s_trig;

  always_comb begin
    bypass  = pq_off_i & ~lsi_i;
    do_eoi  = en_i & eoi_i;
    do_trig = en_i & (trig_i | (eoi_i & lsi_i & level_i));
    pq_d    = pq_q;
    ntf     = 1'b0;
    ntf_chk = 1'b1;
    err_o   = 1'b0;
    s_eoi   = pq_eoi(pq_q);
    s_trig  = pq_trigger(pq_q);
    if (bypass) begin
      err_o = do_eoi;
      if (en_i & trig_i) begin
        ntf     = 1'b1;
        ntf_chk = 1'b0;
      end
    end else begin
      if (do_eoi) begin
        pq_d = s_eoi.pq;
        ntf  = s_eoi.ntf;
      end
      if (do_trig) begin
        s_trig = pq_trigger(pq_d);
        pq_d   = s_trig.pq;
        ntf    = ntf | s_trig.ntf;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q   <= PQ_RESET;
      pend_q <= 1'b0;
      chk_q  <= 1'b1;
    end else begin
      pq_q   <= pq_d;
      pend_q <= (pend_q & ~take_i) | ntf;
      if (ntf) chk_q <= ntf_chk;
    end
  end

  assign pend_o = pend_q;
  assign chk_o  = chk_q;

  a_r6_offload_state_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_off_i && !lsi_i) |=> (pq_q == $past(pq_q)));

  a_r9_out_of_range_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pq_q == $past(pq_q)));

  a_r2_no_q_only_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pq_q != PQ_Q_ONLY);

  a_r10_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q);

endmodule

// File: rtl/pq_rr_arb.sv
module pq_rr_arb #(
  parameter int N = 8
) (
  input  logic [N-1:0]                     req_i,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr_i,
  output logic [N-1:0]                     gnt_o,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx_o,
  output logic                             any_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  int c;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    c     = 0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr_i) + k;
      if (c >= N) c = c - N;
      if (!any_o && req_i[c]) begin
        any_o    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IW'(c);
      end
    end
  end

endmodule

// File: rtl/pq_trigger_gate.sv
module pq_trigger_gate #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pq_off_i,
  input  logic [CNT_W-1:0]   src_count_i,
  input  logic [NUM_SRC-1:0] is_lsi_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] eoi_i,
  output logic               ntf_valid_o,
  input  logic               ntf_ready_i,
  output logic [SRC_W-1:0]   ntf_src_o,
  output logic               ntf_checked_o,
  output logic               eoi_err_o
);

  logic [NUM_SRC-1:0] en, pend, chk, err, gnt, take;
  logic [SRC_W-1:0]   idx, ptr_q;
  logic               any, load;
  logic               out_v_q, out_chk_q, err_q;
  logic [SRC_W-1:0]   out_src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign en[i] = src_count_i > CNT_W'(i);
    pq_src_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[i]),
      .pq_off_i(pq_off_i),
      .lsi_i   (is_lsi_i[i]),
      .level_i (level_i[i]),
      .trig_i  (trig_i[i]),
      .eoi_i   (eoi_i[i]),
      .take_i  (take[i]),
      .pend_o  (pend[i]),
      .chk_o   (chk[i]),
      .err_o   (err[i])
    );
  end

  pq_rr_arb #(.N(NUM_SRC)) u_arb (
    .req_i(pend),
    .ptr_i(ptr_q),
    .gnt_o(gnt),
    .idx_o(idx),
    .any_o(any)
  );

  assign load = ~out_v_q | ntf_ready_i;
  assign take = load ? gnt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q   <= 1'b0;
      out_src_q <= '0;
      out_chk_q <= 1'b0;
      ptr_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= |err;
      if (load) begin
        out_v_q <= any;
        if (any) begin
          out_src_q <= idx;
          out_chk_q <= chk[idx];
          ptr_q     <= (int'(idx) == NUM_SRC - 1) ? '0 : idx + 1'b1;
        end
      end
    end
  end

  assign ntf_valid_o   = out_v_q;
  assign ntf_src_o     = out_src_q;
  assign ntf_checked_o = out_chk_q;
  assign eoi_err_o     = err_q;

  a_r10_hold_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o && !ntf_ready_i) |=> (ntf_valid_o && $stable(ntf_src_o) && $stable(ntf_checked_o)));

  a_r11_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && ((gnt & ~pend) == '0));

  a_r11_grant_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0) |-> any);

  a_r8_err_needs_offload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err != '0) |=> (eoi_err_o && $past(pq_off_i)));

endmodule

// File: tb/tb_pq_trigger_gate.sv
module tb_pq_trigger_gate;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pq_off = 1'b0;
  logic [3:0]   cnt = 4'd8;
  logic [N-1:0] lsi = '0, lvl = '0, trig = '0, eoi = '0;
  logic         ready = 1'b1;
  logic         valid, chkd, err;
  logic [2:0]   src;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int pq [N];
  int last_src = N - 1;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pq_trigger_gate #(.NUM_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pq_off_i(pq_off), .src_count_i(cnt),
    .is_lsi_i(lsi), .level_i(lvl), .trig_i(trig), .eoi_i(eoi),
    .ntf_valid_o(valid), .ntf_ready_i(ready), .ntf_src_o(src),
    .ntf_checked_o(chkd), .eoi_err_o(err)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trig = '0; eoi = '0; lvl = '0; ready = 1'b1;
    for (int i = 0; i < N; i++) pq[i] = 0;
    last_src = N - 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // reference step built from the requirements
  task automatic model(int s, bit t, bit e, bit l, output bit n, output bit c, output bit er);
    n = 0; c = 1; er = 0;
    if (s >= int'(cnt)) return;
    if (pq_off && !lsi[s]) begin
      er = e;
      if (t) begin n = 1; c = 0; end
      return;
    end
    if (e) begin
      if (pq[s] == 3) begin pq[s] = 2; n = 1; end
      else pq[s] = 0;
    end
    if (t || (e && lsi[s] && l)) begin
      if (pq[s] == 0) begin pq[s] = 2; n = 1; end
      else pq[s] = 3;
    end
  endtask

  task automatic op(int s, bit t, bit e, bit l);
    bit n, c, er;
    string tag;
    if (s >= int'(cnt))                 tag = "R9";
    else if (pq_off && !lsi[s] && e)     tag = "R8";
    else if (pq_off && !lsi[s])          tag = "R6";
    else if (lsi[s] && e && l)           tag = "R5";
    else if (pq_off && lsi[s])           tag = "R7";
    else if (t && e)                     tag = "R4";
    else if (e)                          tag = "R3";
    else                                 tag = "R2";
    model(s, t, e, l, n, c, er);
    @(negedge clk);
    trig[s] = t; eoi[s] = e; lvl[s] = l;
    @(negedge clk);
    trig = '0; eoi = '0; lvl = '0;
    check(tag, "eoi_err", int'(err), int'(er));
    @(negedge clk);
    check({tag, "/R12"}, "valid", int'(valid), int'(n));
    if (n) begin
      check(tag, "src", int'(src), s);
      check(tag, "checked", int'(chkd), int'(c));
      last_src = s;
    end
    @(negedge clk);
    check(tag, "drained valid", int'(valid), 0);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    do_reset();
    check("R1", "valid after reset", int'(valid), 0);
    check("R1", "err after reset", int'(err), 0);
    // R1: first trigger on a fresh source must notify from 00
    op(3, 1, 0, 0);

    for (int ph = 0; ph < 6; ph++) begin
      pq_off = ph[0];
      lsi    = ph[1] ? 8'hA5 : 8'h5A;
      cnt    = (ph >= 4) ? 4'd5 : 4'd8;
      for (int k = 0; k < 160; k++) begin
        int s; bit t, e, l;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s = int'(lfsr[2:0]);
        t = lfsr[3] | ~lfsr[4];
        e = lfsr[4];
        l = lfsr[5];
        op(s, t, e, l);
      end
    end

    // R9 follow-up: sources 5..7 untouched while out of range, now visible again
    cnt = 4'd8; pq_off = 1'b0;
    for (int s = 5; s < N; s++) op(s, 1, 0, 0);

    // R10 / R11: stall with several requests, then rotating drain
    do_reset();
    pq_off = 1'b0; lsi = '0; cnt = 4'd8;
    @(negedge clk);
    ready = 1'b0;
    trig = 8'b0010_0110;
    @(negedge clk);
    trig = '0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check("R10", "stalled valid", int'(valid), 1);
      check("R10", "stalled src", int'(src), 1);
      check("R10", "stalled checked", int'(chkd), 1);
      @(negedge clk);
    end
    ready = 1'b1;
    @(negedge clk);
    check("R11", "second grant", int'(src), 2);
    check("R11", "second valid", int'(valid), 1);
    @(negedge clk);
    check("R11", "third grant", int'(src), 5);
    @(negedge clk);
    check("R11", "drained", int'(valid), 0);
    // pointer now at 6: source 0 must beat source 3
    trig = 8'b0000_1001;
    @(negedge clk);
    trig = '0;
    @(negedge clk);
    check("R11", "wrap grant", int'(src), 0);
    @(negedge clk);
    check("R11", "next grant", int'(src), 3);
    @(negedge clk);
    check("R11", "drained again", int'(valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule